// File: doc/BRIEF.md
# Binary-Tree Demultiplexing Deserializer

This block sits behind the optical receiver of a link and turns a source-synchronous serial stream into parallel words. The stream arrives on 1, 2 or 4 lanes, one bit per lane per fast clock. A chain of 1:2 demultiplexing stages rebuilds each word. Every stage runs at half the rate of the stage before it, and every stage doubles the width of the group it holds. One fast clock drives the whole tree. The forwarded clock, halved at each stage, is modelled by a phase tag that travels down the tree with the data and picks which half of the next stage is written.

The slot counter is aligned by a start-of-frame pulse that marks the first slot of a word. From then on, one word is delivered every `WORD_W/LANES` cycles with a valid strobe. A free-running word-rate enable marks each word boundary, whether or not the stream has been framed. A single bit of the recovered word, the virtual-channel flag, steers the word to a request strobe or to a reply strobe.

Top module: `deser_tree`

## Requirements
- R1: In the k-th cycle of a word (k = 0 is the cycle that carries the start-of-frame pulse, or the cycle after the previous word ended), lane l carries word bit k*LANES + l. `word_out` holds its value between word-rate enables.
- R2: `word_valid` stays low after reset until the first word that starts at or after a start-of-frame pulse has been fully received.
- R3: `word_en` is a single-cycle pulse at every word boundary, once per `WORD_W/LANES` cycles, and it runs from reset whether or not the stream is framed. `word_valid` is high only together with `word_en`.
- R4: `word_valid` for a word rises on the clock edge that comes `log2(WORD_W/LANES)` edges after the edge that samples the last slot of that word. Measured from the edge that samples the start-of-frame pulse, this is `WORD_W/LANES - 1 + log2(WORD_W/LANES)` edges.
- R5: A start-of-frame pulse in the middle of a word drops the partial word. The next word delivered is the one that starts with that pulse.
- R6: Back-to-back words sent with no further start-of-frame pulse are all delivered, in order, with their `word_valid` pulses exactly `WORD_W/LANES` cycles apart.
- R7: With `word_valid` high, a word whose bit `VC_BIT` is 0 raises `req_valid`, and a word whose bit `VC_BIT` is 1 raises `rep_valid`. Neither strobe is ever high without `word_valid`, and the two are never high together.
- R8: During reset, `word_out` is zero and `word_en`, `word_valid`, `req_valid` and `rep_valid` are low. Reset is applied asynchronously and released through a two-flop synchroniser.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast bit clock, forwarded with the data |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof | input | 1 | Start-of-frame pulse, high in the first slot of a word |
| ser_in | input | LANES | Serial data, one bit per lane per cycle |
| word_out | output | WORD_W | Recovered parallel word |
| word_en | output | 1 | Word-rate enable, one cycle per word boundary |
| word_valid | output | 1 | The word on `word_out` is framed and complete |
| req_valid | output | 1 | Valid word of the request class (VC bit 0) |
| rep_valid | output | 1 | Valid word of the reply class (VC bit 1) |

## Verification
The bench builds the block with a 16-bit word on two lanes. This gives eight slots per word and a three-stage tree, so each stage writes a half of a different width and the lane interleave is visible in every bit pair. With this setting, the delivery latency after the last slot (three edges) differs from the spacing between words (eight cycles), so a stage that is skipped or added shows up as a timing error. The realignment case cuts a word off after three slots, while the last framed word is still inside the tree. This makes the bench show that the in-flight word and the partial word are handled separately.

// File: rtl/deser_pkg.sv
package deser_pkg;
  // Class of a recovered word, selected by one bit of the word.
  typedef enum logic {
    VC_REQ = 1'b0,
    VC_REP = 1'b1
  } vc_class_t;
endpackage

// File: rtl/deser_phase.sv
// Slot counter standing in for the forwarded-clock divider chain.
// A start-of-frame pulse forces the current slot to zero and arms the block.
module deser_phase #(
  parameter int unsigned SLOTS = 8,
  parameter int unsigned CW    = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sof,
  output logic [CW-1:0] slot,
  output logic          arm
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          armed_q, armed_d;

  always_comb begin
    slot    = sof ? '0 : cnt_q;
    arm     = sof | armed_q;
    cnt_d   = slot + 1'b1;
    armed_d = arm;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end
endmodule

// File: rtl/deser_stage.sv
// One 1:2 level of the tree. An incoming group goes to the lower or the upper
// half, chosen by bit 0 of the phase tag. Writing the upper half completes
// the doubled group and fires the strobe for the next level.
module deser_stage #(
  parameter int unsigned LANES = 2,
  parameter int unsigned IN_E  = 1,
  parameter int unsigned TAG_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_v,
  input  logic                      in_arm,
  input  logic [TAG_W-1:0]          in_tag,
  input  logic [LANES*IN_E-1:0]     in_grp,
  output logic                      out_v,
  output logic                      out_arm,
  output logic [TAG_W-1:0]          out_tag,
  output logic [2*LANES*IN_E-1:0]   out_grp
);
  localparam int unsigned HW = LANES * IN_E;

  logic             v_d, arm_d;
  logic [TAG_W-1:0] tag_d;
  logic [2*HW-1:0]  grp_d;

  always_comb begin
    v_d   = in_v & in_tag[0];
    arm_d = in_v ? in_arm : out_arm;
    tag_d = in_v ? (in_tag >> 1) : out_tag;
    grp_d = out_grp;
    if (in_v) begin
      if (in_tag[0]) grp_d[2*HW-1:HW] = in_grp;
      else           grp_d[HW-1:0]    = in_grp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_v   <= 1'b0;
      out_arm <= 1'b0;
      out_tag <= '0;
    end else begin
      out_v   <= v_d;
      out_arm <= arm_d;
      out_tag <= tag_d;
    end
  end

  // Datapath storage carries no reset; it is qualified by out_v.
  always_ff @(posedge clk) begin
    out_grp <= grp_d;
  end
endmodule

// File: rtl/deser_tree.sv
module deser_tree
  import deser_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned LANES  = 2,
  parameter int unsigned VC_BIT = WORD_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof,
  input  logic [LANES-1:0]  ser_in,
  output logic [WORD_W-1:0] word_out,
  output logic              word_en,
  output logic              word_valid,
  output logic              req_valid,
  output logic              rep_valid
);
  localparam int unsigned SLOTS  = WORD_W / LANES;
  localparam int unsigned STAGES = $clog2(SLOTS);
  localparam int unsigned CW     = STAGES;

  // Asynchronous assert, synchronous release.
  logic [1:0] rs_q;
  logic       rst_ln;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ln = rs_q[1];

  logic [CW-1:0] slot;
  logic          arm;

  deser_phase #(.SLOTS(SLOTS), .CW(CW)) u_phase (
    .clk   (clk),
    .rst_n (rst_ln),
    .sof   (sof),
    .slot  (slot),
    .arm   (arm)
  );

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    localparam int unsigned IE = 2 ** s;
    logic                    iv, ia, ov, oa;
    logic [CW-1:0]           it, ot;
    logic [LANES*IE-1:0]     ig;
    logic [2*LANES*IE-1:0]   og;

    if (s == 0) begin : g_head
      assign iv = 1'b1;
      assign ia = arm;
      assign it = slot;
      assign ig = ser_in;
    end else begin : g_link
      assign iv = g_stg[s-1].ov;
      assign ia = g_stg[s-1].oa;
      assign it = g_stg[s-1].ot;
      assign ig = g_stg[s-1].og;
    end

    deser_stage #(.LANES(LANES), .IN_E(IE), .TAG_W(CW)) u_stage (
      .clk     (clk),
      .rst_n   (rst_ln),
      .in_v    (iv),
      .in_arm  (ia),
      .in_tag  (it),
      .in_grp  (ig),
      .out_v   (ov),
      .out_arm (oa),
      .out_tag (ot),
      .out_grp (og)
    );
  end

  logic              fin_v, fin_arm;
  logic [WORD_W-1:0] fin_grp;
  logic              unused_tag;
  assign fin_v      = g_stg[STAGES-1].ov;
  assign fin_arm    = g_stg[STAGES-1].oa;
  assign fin_grp    = g_stg[STAGES-1].og;
  assign unused_tag = ^g_stg[STAGES-1].ot;

  logic [WORD_W-1:0] word_q, word_d;
  logic              en_q, en_d, val_q, val_d;

  always_comb begin
    word_d = fin_v ? fin_grp : word_q;
    en_d   = fin_v;
    val_d  = fin_v & fin_arm;
  end

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) begin
      word_q <= '0;
      en_q   <= 1'b0;
      val_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      en_q   <= en_d;
      val_q  <= val_d;
    end
  end

  vc_class_t vc;
  assign vc         = vc_class_t'(word_q[VC_BIT]);
  assign word_out   = word_q;
  assign word_en    = en_q;
  assign word_valid = val_q;
  assign req_valid  = val_q && (vc == VC_REQ);
  assign rep_valid  = val_q && (vc == VC_REP);
endmodule

// File: rtl/deser_tree_chk.sv
module deser_tree_chk #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned LANES  = 2,
  parameter int unsigned VC_BIT = WORD_W - 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sof,
  input logic [WORD_W-1:0] word_out,
  input logic              word_en,
  input logic              word_valid,
  input logic              req_valid,
  input logic              rep_valid
);
  logic seen_q;
  logic unused_lanes;
  assign unused_lanes = (LANES == 0) || (VC_BIT >= WORD_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   seen_q <= 1'b0;
    else if (sof) seen_q <= 1'b1;
  end

  a_r2_no_valid_unframed: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> seen_q);

  a_r3_valid_with_en: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> word_en);

  a_r3_en_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    word_en |=> !word_en);

  a_r1_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !word_en |-> $stable(word_out));

  a_r7_class_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && rep_valid));

  a_r7_class_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid || rep_valid) |-> word_valid);

  a_r7_class_one_hot: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> ($countones({req_valid, rep_valid}) == 1));
endmodule

bind deser_tree deser_tree_chk #(
  .WORD_W (WORD_W),
  .LANES  (LANES),
  .VC_BIT (VC_BIT)
) u_chk (.*);

// File: tb/deser_tree_tb.sv
module deser_tree_tb;
  localparam int unsigned WW = 16;
  localparam int unsigned LN = 2;
  localparam int unsigned SL = WW / LN;
  localparam int unsigned ST = $clog2(SL);

  localparam logic [WW-1:0] VEC [8] = '{
    16'h0000, 16'hFFFF, 16'h8001, 16'h1234,
    16'hCAFE, 16'h5A5A, 16'h7F00, 16'h00FF
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, sof;
  logic [LN-1:0] ser_in;
  logic [WW-1:0] word_out;
  logic          word_en, word_valid, req_valid, rep_valid;

  deser_tree #(.WORD_W(WW), .LANES(LN), .VC_BIT(WW-1)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .sof        (sof),
    .ser_in     (ser_in),
    .word_out   (word_out),
    .word_en    (word_en),
    .word_valid (word_valid),
    .req_valid  (req_valid),
    .rep_valid  (rep_valid)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  logic [WW-1:0] expq [0:63];
  logic [WW-1:0] seen [0:63];
  int  wr = 0, rd = 0;
  bit  armed_tb = 0, mon_en = 0, spc_chk = 0, lat_pend = 0, phase_a = 0;
  int  last_v = -1, sof_cyc = 0, pre_val = 0, en_seen = 0;
  bit  done = 0;

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // Send n slots of word w; slot k carries bits k*LN .. k*LN+LN-1 (R1 ordering).
  task automatic send(input logic [WW-1:0] w, input int n, input bit s, input bit push);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      sof = s && (k == 0);
      if (s && k == 0) begin
        armed_tb = 1;
        sof_cyc  = cyc;
      end
      for (int l = 0; l < LN; l++) ser_in[l] = w[k*LN + l];
    end
    if (push && armed_tb) begin
      expq[wr] = w;
      wr++;
    end
  endtask

  always @(negedge clk) begin
    if (phase_a) begin
      if (word_valid) pre_val++;
      if (word_en)    en_seen++;
    end
    if (mon_en && word_valid) begin
      check(word_en, "R3 valid without word_en", word_en, 1);
      if (rd < wr) begin
        check(word_out == expq[rd], "R1 recovered word", word_out, expq[rd]);
        check(req_valid == !expq[rd][WW-1] && rep_valid == expq[rd][WW-1],
              "R7 class strobes", {req_valid, rep_valid},
              {!expq[rd][WW-1], expq[rd][WW-1]});
        seen[rd] = word_out;
        rd++;
      end else begin
        check(0, "R5 unexpected word", word_out, 0);
      end
      if (spc_chk && last_v >= 0)
        check(cyc - last_v == SL, "R6 word spacing", cyc - last_v, SL);
      last_v = cyc;
      if (lat_pend) begin
        check(cyc - sof_cyc == SL + ST, "R4 latency", cyc - sof_cyc, SL + ST);
        lat_pend = 0;
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    check(0, "watchdog expired", cyc, 0);
    finish_run();
  end

  int idx_a5;

  initial begin
    rst_n = 1'b0; sof = 1'b0; ser_in = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    check(word_out == '0, "R8 reset word", word_out, 0);
    check(!word_valid && !word_en, "R8 reset strobes", {word_valid, word_en}, 0);
    check(!req_valid && !rep_valid, "R8 reset class", {req_valid, rep_valid}, 0);
    rst_n = 1'b1;
    mon_en = 1;

    // R2 / R3: unframed stream gives enables but never a valid word
    phase_a = 1;
    for (int i = 0; i < 3; i++) send(16'hBEEF, SL, 0, 1);
    @(negedge clk);
    phase_a = 0;
    check(pre_val == 0, "R2 valid before framing", pre_val, 0);
    check(en_seen >= 2, "R3 free-running word_en", en_seen, 2);

    // R1 / R4 / R6 / R7: framed back-to-back words from the vector table
    lat_pend = 1;
    spc_chk  = 1;
    foreach (VEC[i]) send(VEC[i], SL, i == 0, 1);
    spc_chk  = 0;

    // R5: realign after three slots of a partial word
    send(16'hFFFF, 3, 1, 0);
    idx_a5 = wr;
    send(16'hA5C3, SL, 1, 1);
    send(16'h0001, SL, 0, 1);
    send(16'h8000, SL, 0, 1);

    @(negedge clk);
    sof = 1'b0; ser_in = '0;
    repeat (ST + 2) @(negedge clk);
    mon_en = 0;

    check(rd == wr, "R6 all words delivered", rd, wr);
    check(seen[idx_a5] == 16'hA5C3, "R5 word after realign", seen[idx_a5], 16'hA5C3);
    check(lat_pend == 0, "R4 first framed word seen", lat_pend, 0);
    finish_run();
  end
endmodule